// File: doc/BRIEF.md
# Page Table Word Cache

This block keeps recently fetched page-directory and page-table words close to the translation walker. The walker presents a physical byte address and a transaction id. If the 32-byte memory atom holding that word is resident, the word comes back on the next cycle. If it is not, the block sends one atom-aligned read to memory, tagged with the walker's id. When the atom returns, the block answers the walker with the selected 32-bit word and installs the atom in a line. Because responses carry the id, memory may return atoms in any order.

The cache is direct-mapped. The line index is the low bits of the atom address masked by a programmable index-map field. A configuration word sets three things: a global enable (when clear, every read goes to memory and nothing is filled), a cap on the number of outstanding memory reads, and the index map. Software invalidates lines through a flush word:

- With bit 0 clear, the flush drops every line.
- With bit 0 set, the flush drops only the line holding the atom that contains the address.

That address takes bits 31:0 from the flush word and bits 33:32 from a separate two-bit high register, which must be written first.

Top module: `pte_word_cache`

## Requirements
- R1: A read whose atom is resident in its line (tag equal to the full atom address) is accepted without a memory request, and the next cycle returns rsp_valid with the requesting id and the word selected by address bits 4:2.
- R2: A read that misses issues a memory request at the address aligned down to 32 bytes, tagged with the read's id. One cycle after the memory response, rsp_valid rises with rsp_id equal to the response tag and the word picked by bits 4:2 of the original address, whatever the order of the responses.
- R3: The line index is atom-address bits 3:0 ANDed with config bits 3:0 of the index-map field. A fill replaces whatever the line held, so two atoms with the same masked index evict each other, and a map of zero folds every atom onto line 0.
- R4: In the config word, bit 29 enables the cache, bits 27:24 are the outstanding limit and bits 5:0 are the index map. The word resets to zero. While bit 29 is clear, every read goes to memory, including reads of resident atoms, and the returned atom is not installed.
- R5: When the limit is non-zero and the outstanding count equals it, a missing read is held (req_ready low, no memory request) until a response returns, while a hitting read is still accepted. A limit of zero places no cap.
- R6: A flush write with bit 0 equal to 0 invalidates every line.
- R7: A flush write with bit 0 equal to 1 forms the address from the high register and the flush word, aligns it down to 32 bytes and invalidates only the line holding that atom. If no line holds that atom, the write has no effect.
- R8: The high register holds two bits that supply address bits 33:32 for every later flush-by-address until it is written again. It resets to zero.
- R9: In a cycle with a memory response, req_ready is low.
- R10: After reset there is no response, no memory request, every line is invalid and the block accepts reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the config word |
| cfg_wdata | input | 32 | Config word: enable, outstanding limit, index map |
| flush_hi_we | input | 1 | Write strobe for the flush high register |
| flush_hi_wdata | input | 2 | Physical address bits 33:32 for flush-by-address |
| flush_we | input | 1 | Flush command strobe |
| flush_wdata | input | 32 | Bit 0 selects the type; bits 31:0 form the low address |
| req_valid | input | 1 | Walker read valid |
| req_ready | output | 1 | Walker read accepted this cycle |
| req_addr | input | 34 | Physical byte address of the word |
| req_id | input | 4 | Walker transaction id |
| rsp_valid | output | 1 | Read data valid |
| rsp_id | output | 4 | Id of the answered read |
| rsp_data | output | 32 | Returned word |
| mem_req_valid | output | 1 | Memory atom read valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 34 | Atom-aligned memory address |
| mem_req_tag | output | 4 | Tag echoed by memory |
| mem_rsp_valid | input | 1 | Memory atom returned |
| mem_rsp_tag | input | 4 | Tag of the returned atom |
| mem_rsp_data | input | 256 | Returned atom, word 0 in the low bits |

## Verification
The properties assume three things about the inputs. First, the walker never reuses an id that is still waiting on memory. Second, memory answers only tags it has accepted, and answers each of them once. Third, the limit is not lowered below the current outstanding count. The bench acts as both walker and memory from a single sequential thread. It hands out distinct ids to reads in flight and returns each issued tag exactly once, from the address it recorded for that tag. It also changes the config only while nothing is outstanding.

// File: rtl/pte_word_cache.sv
module pte_word_cache #(
  parameter int ADDR_W     = 34,
  parameter int ATOM_BYTES = 32,
  parameter int LINES      = 16,
  parameter int ID_W       = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [31:0]             cfg_wdata,
  input  logic                    flush_hi_we,
  input  logic [ADDR_W-33:0]      flush_hi_wdata,
  input  logic                    flush_we,
  input  logic [31:0]             flush_wdata,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [ID_W-1:0]         req_id,
  output logic                    rsp_valid,
  output logic [ID_W-1:0]         rsp_id,
  output logic [31:0]             rsp_data,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [ADDR_W-1:0]       mem_req_addr,
  output logic [ID_W-1:0]         mem_req_tag,
  input  logic                    mem_rsp_valid,
  input  logic [ID_W-1:0]         mem_rsp_tag,
  input  logic [ATOM_BYTES*8-1:0] mem_rsp_data
);
  localparam int OFF_W  = $clog2(ATOM_BYTES);
  localparam int WORDS  = ATOM_BYTES / 4;
  localparam int WSEL_W = $clog2(WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int HI_W   = ADDR_W - 32;
  localparam int SLOTS  = 2 ** ID_W;
  localparam int CNT_W  = (ID_W + 1 > 5) ? ID_W + 1 : 5;

  logic             cfg_en;
  logic [3:0]       cfg_limit;
  logic [5:0]       cfg_map;
  logic [HI_W-1:0]  hi_q;

  logic [LINES-1:0]             vld, vld_n;
  logic [TAG_W-1:0]             tag_q [LINES];
  logic [WORDS-1:0][31:0]       dat_q [LINES];

  logic [TAG_W-1:0]  pend_atom [SLOTS];
  logic [WSEL_W-1:0] pend_wsel [SLOTS];
  logic [SLOTS-1:0]  pend_fill;
  logic [CNT_W-1:0]  outstanding;

  logic [IDX_W-1:0]  map_mask;
  assign map_mask = cfg_map[IDX_W-1:0];

  logic [TAG_W-1:0]  req_atom;
  logic [WSEL_W-1:0] req_wsel;
  logic [IDX_W-1:0]  req_idx;
  logic              hit, room, miss_go, hit_go;

  assign req_atom = req_addr[ADDR_W-1:OFF_W];
  assign req_wsel = req_addr[OFF_W-1:2];
  assign req_idx  = req_atom[IDX_W-1:0] & map_mask;
  assign hit      = cfg_en && vld[req_idx] && (tag_q[req_idx] == req_atom);
  assign room     = (cfg_limit == 4'd0) || (outstanding < CNT_W'(cfg_limit));

  assign mem_req_valid = req_valid && !hit && room && !mem_rsp_valid;
  assign mem_req_addr  = {req_atom, {OFF_W{1'b0}}};
  assign mem_req_tag   = req_id;
  assign req_ready     = !mem_rsp_valid && (hit || (room && mem_req_ready));
  assign miss_go       = mem_req_valid && mem_req_ready;
  assign hit_go        = req_valid && req_ready && hit;

  logic [WORDS-1:0][31:0] rsp_words;
  logic [TAG_W-1:0]       fill_atom;
  logic [IDX_W-1:0]       fill_idx;
  logic                   fill_do;

  assign rsp_words = mem_rsp_data;
  assign fill_atom = pend_atom[mem_rsp_tag];
  assign fill_idx  = fill_atom[IDX_W-1:0] & map_mask;
  assign fill_do   = mem_rsp_valid && pend_fill[mem_rsp_tag];

  logic [ADDR_W-1:0] fl_addr;
  logic [TAG_W-1:0]  fl_atom;
  logic [IDX_W-1:0]  fl_idx;
  logic              fl_all, fl_one, fl_match;

  assign fl_addr  = {hi_q, flush_wdata};
  assign fl_atom  = fl_addr[ADDR_W-1:OFF_W];
  assign fl_idx   = fl_atom[IDX_W-1:0] & map_mask;
  assign fl_all   = flush_we && !flush_wdata[0];
  assign fl_one   = flush_we && flush_wdata[0];
  assign fl_match = (vld[fl_idx] && tag_q[fl_idx] == fl_atom) ||
                    (fill_do && fill_idx == fl_idx && fill_atom == fl_atom);

  logic unused_bits;
  assign unused_bits = ^{cfg_wdata[31:30], cfg_wdata[28], cfg_wdata[23:6],
                         flush_wdata[OFF_W-1:1], req_addr[1:0]};

  always_comb begin
    vld_n = vld;
    if (fill_do) vld_n[fill_idx] = 1'b1;
    if (fl_all) vld_n = '0;
    else if (fl_one && fl_match) vld_n[fl_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en    <= 1'b0;
      cfg_limit <= '0;
      cfg_map   <= '0;
      hi_q      <= '0;
      vld       <= '0;
    end else begin
      if (cfg_we) begin
        cfg_en    <= cfg_wdata[29];
        cfg_limit <= cfg_wdata[27:24];
        cfg_map   <= cfg_wdata[5:0];
      end
      if (flush_hi_we) hi_q <= flush_hi_wdata;
      vld <= vld_n;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_do) begin
      tag_q[fill_idx] <= fill_atom;
      dat_q[fill_idx] <= rsp_words;
    end
    if (miss_go) begin
      pend_atom[req_id] <= req_atom;
      pend_wsel[req_id] <= req_wsel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_fill   <= '0;
      outstanding <= '0;
    end else begin
      if (miss_go) begin
        pend_fill[req_id] <= cfg_en;
        outstanding       <= outstanding + 1'b1;
      end else if (mem_rsp_valid) begin
        outstanding       <= outstanding - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= mem_rsp_valid || hit_go;
      if (mem_rsp_valid) begin
        rsp_id   <= mem_rsp_tag;
        rsp_data <= rsp_words[pend_wsel[mem_rsp_tag]];
      end else if (hit_go) begin
        rsp_id   <= req_id;
        rsp_data <= dat_q[req_idx][req_wsel];
      end
    end
  end
endmodule

// File: rtl/pte_word_cache_chk.sv
module pte_word_cache_chk #(
  parameter int ID_W  = 4,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [ID_W-1:0]  req_id,
  input logic             rsp_valid,
  input logic [ID_W-1:0]  rsp_id,
  input logic             mem_req_valid,
  input logic             mem_rsp_valid,
  input logic [ID_W-1:0]  mem_rsp_tag,
  input logic             cfg_en,
  input logic [3:0]       cfg_limit,
  input logic [CNT_W-1:0] outstanding
);
  a_r5_no_miss_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_limit != 4'd0 && outstanding >= CNT_W'(cfg_limit)) |-> !mem_req_valid);

  a_r1_hit_answers_next: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !mem_req_valid) |=> (rsp_valid && rsp_id == $past(req_id)));

  a_r2_fill_answers_next: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |=> (rsp_valid && rsp_id == $past(mem_rsp_tag)));

  a_r4_bypass_fetches: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && req_valid && req_ready) |-> mem_req_valid);

  a_r9_fill_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !req_ready);

  a_r10_rsp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(mem_rsp_valid) || $past(req_valid && req_ready)));
endmodule

bind pte_word_cache pte_word_cache_chk #(.ID_W(ID_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_id(req_id), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
  .mem_req_valid(mem_req_valid), .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_tag(mem_rsp_tag), .cfg_en(cfg_en), .cfg_limit(cfg_limit),
  .outstanding(outstanding)
);

// File: tb/pte_word_cache_bench.sv
module pte_word_cache_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 0, flush_hi_we = 0, flush_we = 0;
  logic [31:0]  cfg_wdata = '0, flush_wdata = '0;
  logic [1:0]   flush_hi_wdata = '0;
  logic         req_valid = 0, req_ready;
  logic [33:0]  req_addr = '0;
  logic [3:0]   req_id = '0;
  logic         rsp_valid;
  logic [3:0]   rsp_id;
  logic [31:0]  rsp_data;
  logic         mem_req_valid, mem_req_ready = 1'b1;
  logic [33:0]  mem_req_addr;
  logic [3:0]   mem_req_tag;
  logic         mem_rsp_valid = 0;
  logic [3:0]   mem_rsp_tag = '0;
  logic [255:0] mem_rsp_data = '0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pte_word_cache u_pte_word_cache (
    .clk, .rst_n, .cfg_we, .cfg_wdata, .flush_hi_we, .flush_hi_wdata,
    .flush_we, .flush_wdata, .req_valid, .req_ready, .req_addr, .req_id,
    .rsp_valid, .rsp_id, .rsp_data, .mem_req_valid, .mem_req_ready,
    .mem_req_addr, .mem_req_tag, .mem_rsp_valid, .mem_rsp_tag, .mem_rsp_data
  );

  localparam logic [33:0] A = 34'h0_0000_1020, B = 34'h0_0000_1040, C = 34'h0_0000_1220;
  localparam logic [33:0] D = 34'h2_0000_0060;
  localparam logic [33:0] E = 34'h0_0000_3080, F = 34'h0_0000_30A0;
  localparam logic [33:0] G = 34'h0_0000_30C0, H = 34'h0_0000_30E0;

  localparam logic [34:0] VEC [8] = '{
    {A,             1'b1},
    {A + 34'h4,     1'b0},
    {B,             1'b1},
    {A + 34'h1C,    1'b0},
    {C,             1'b1},
    {A + 34'h8,     1'b1},
    {C + 34'h8,     1'b1},
    {B + 34'h10,    1'b0}
  };

  function automatic logic [31:0] word_at(logic [33:0] a);
    return a[31:0] ^ {a[33:32], 30'h0} ^ 32'h5A00_0000;
  endfunction

  function automatic logic [255:0] atom_at(logic [33:0] base);
    logic [255:0] r;
    for (int w = 0; w < 8; w++) r[w*32 +: 32] = word_at(base + 34'(w * 4));
    return r;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wcfg(input bit en, input logic [3:0] lim, input logic [5:0] map);
    @(negedge clk); cfg_we = 1; cfg_wdata = {2'b0, en, 1'b0, lim, 18'b0, map};
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wr_hi(input logic [1:0] h);
    @(negedge clk); flush_hi_we = 1; flush_hi_wdata = h;
    @(negedge clk); flush_hi_we = 0;
  endtask

  task automatic wr_flush(input logic [31:0] w);
    @(negedge clk); flush_we = 1; flush_wdata = w;
    @(negedge clk); flush_we = 0;
  endtask

  task automatic issue(input logic [33:0] a, input logic [3:0] id,
                       output bit miss, output logic [33:0] maddr, output logic [3:0] tag);
    @(negedge clk); req_valid = 1; req_addr = a; req_id = id; #1;
    for (int k = 0; k < 50 && !req_ready; k++) begin @(negedge clk); #1; end
    miss = mem_req_valid; maddr = mem_req_addr; tag = mem_req_tag;
    @(negedge clk); req_valid = 0;
  endtask

  task automatic respond(input logic [33:0] maddr, input logic [3:0] tag);
    mem_rsp_valid = 1; mem_rsp_tag = tag; mem_rsp_data = atom_at(maddr);
    @(negedge clk); mem_rsp_valid = 0;
  endtask

  task automatic rsp_check(input logic [33:0] a, input logic [3:0] id, input string rq);
    chk(rsp_valid && rsp_id == id && rsp_data == word_at(a), rq,
        {27'b0, rsp_valid, rsp_id, rsp_data}, {27'b0, 1'b1, id, word_at(a)});
  endtask

  task automatic rd(input logic [33:0] a, input logic [3:0] id, input bit exp_miss, input string rq);
    bit m; logic [33:0] ma; logic [3:0] tg;
    issue(a, id, m, ma, tg);
    chk(m == exp_miss, rq, 64'(m), 64'(exp_miss));
    if (m) begin
      chk(ma == {a[33:5], 5'b0} && tg == id, "R2 request", {26'b0, tg, ma}, {26'b0, id, a[33:5], 5'b0});
      respond(ma, tg);
    end
    rsp_check(a, id, rq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit m1, m2, m3; logic [33:0] a1, a2, a3; logic [3:0] t1, t2, t3;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!rsp_valid && !mem_req_valid && req_ready, "R10 reset",
        {61'b0, rsp_valid, mem_req_valid, req_ready}, 64'h1);

    // R4: reset config is disabled, so even repeats fetch
    rd(A, 4'd0, 1'b1, "R4 default bypass");
    rd(A, 4'd1, 1'b1, "R4 default bypass repeat");

    wcfg(1'b1, 4'd0, 6'h3F);
    for (int i = 0; i < 8; i++)
      rd(VEC[i][34:1], 4'(i), VEC[i][0], "R1/R3 table");

    // R6 flush all
    wr_flush(32'h0000_0000);
    rd(B, 4'd2, 1'b1, "R6 flush all");

    // R3 map folding
    wcfg(1'b1, 4'd0, 6'h00);
    rd(A, 4'd3, 1'b1, "R3 map zero fill");
    rd(A + 34'h4, 4'd4, 1'b0, "R3 map zero hit");
    rd(B, 4'd5, 1'b1, "R3 map zero evict");
    rd(A, 4'd6, 1'b1, "R3 map zero refetch");
    wcfg(1'b1, 4'd0, 6'h3F);
    rd(A, 4'd7, 1'b1, "R3 map restored fill");

    // R7 flush by address, unaligned with type bit
    wr_hi(2'd0);
    wr_flush(A[31:0] + 32'h15);
    rd(B, 4'd8, 1'b0, "R7 other line kept");
    rd(A, 4'd9, 1'b1, "R7 line dropped");
    wr_flush(32'h0000_5041);
    rd(B, 4'd10, 1'b0, "R7 no match no effect");
    rd(A + 34'h4, 4'd11, 1'b0, "R7 no match no effect");

    // R8 high address bits
    rd(D, 4'd0, 1'b1, "R8 fill high");
    rd(D, 4'd1, 1'b0, "R8 hit high");
    wr_flush(32'h0000_0061);
    rd(D, 4'd2, 1'b0, "R8 wrong high kept");
    wr_hi(2'd2);
    wr_flush(32'h0000_0061);
    rd(D, 4'd3, 1'b1, "R8 high flush");
    wr_flush(32'h0000_0061);
    rd(D + 34'h4, 4'd4, 1'b1, "R8 high retained");

    // R5 limit stall, R9 priority, out-of-order R2
    wcfg(1'b1, 4'd2, 6'h3F);
    wr_flush(32'h0);
    rd(H, 4'd5, 1'b1, "R5 prefill");
    issue(E, 4'd1, m1, a1, t1);
    issue(F, 4'd2, m2, a2, t2);
    chk(m1 && m2, "R5 two misses", {62'b0, m1, m2}, 64'h3);
    @(negedge clk); req_valid = 1; req_addr = G; req_id = 4'd3; #1;
    chk(!req_ready && !mem_req_valid, "R5 miss held", {62'b0, req_ready, mem_req_valid}, 64'h0);
    req_addr = H + 34'h4; req_id = 4'd4; #1;
    chk(req_ready && !mem_req_valid, "R5 hit at limit", {62'b0, req_ready, mem_req_valid}, 64'h2);
    mem_rsp_valid = 1; mem_rsp_tag = t2; mem_rsp_data = atom_at(a2); #1;
    chk(!req_ready, "R9 response priority", 64'(req_ready), 64'h0);
    @(negedge clk); mem_rsp_valid = 0;
    rsp_check(F, 4'd2, "R2 out of order");
    #1; chk(req_ready, "R5 hit after response", 64'(req_ready), 64'h1);
    @(negedge clk); req_valid = 0;
    rsp_check(H + 34'h4, 4'd4, "R1 hit under miss");
    respond(a1, t1);
    rsp_check(E, 4'd1, "R2 second response");
    rd(G, 4'd3, 1'b1, "R5 released");

    // R5 limit zero is uncapped
    wcfg(1'b1, 4'd0, 6'h3F);
    wr_flush(32'h0);
    issue(E + 34'h4, 4'd6, m1, a1, t1);
    issue(F + 34'h8, 4'd7, m2, a2, t2);
    issue(G + 34'hC, 4'd8, m3, a3, t3);
    chk(m1 && m2 && m3, "R5 zero limit", {61'b0, m1, m2, m3}, 64'h7);
    respond(a3, t3); rsp_check(G + 34'hC, 4'd8, "R2 tag 8");
    respond(a1, t1); rsp_check(E + 34'h4, 4'd6, "R2 tag 6");
    respond(a2, t2); rsp_check(F + 34'h8, 4'd7, "R2 tag 7");
    rd(F, 4'd9, 1'b0, "R2 fill installed");

    // R4 bypass ignores resident lines and does not fill
    wcfg(1'b0, 4'd0, 6'h3F);
    rd(F, 4'd10, 1'b1, "R4 bypass resident");
    rd(B, 4'd11, 1'b1, "R4 bypass fetch");
    wcfg(1'b1, 4'd0, 6'h3F);
    rd(B, 4'd12, 1'b1, "R4 bypass no fill");
    rd(B, 4'd13, 1'b0, "R4 enabled fill");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule